// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block decides where the two ALU operand latches of the instruction in the execute stage (stage 3) of a five-stage pipeline get their values. The first operand (X) belongs to source field B. The second operand (Y) belongs to source field C.

Each operand normally takes the value read from the register file. When an older ALU-class instruction still in stage 4 or stage 5 is about to write the register that stage 3 reads, that instruction's result is passed straight to the operand instead. This removes the read-after-write hazard between ALU instructions without a stall.

The block has no state. Every output settles within the cycle from the current contents of the pipeline registers that feed it. For each operand it also reports a 2-bit code naming the path it chose, so surrounding logic and test code can see that choice. Forwarding from loads, stall generation and the register file itself are handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: When stages 5 and 3 are both ALU-class, the stage-5 destination equals source field B, and R7 does not apply, X equals the stage-5 result and xSel is 2'b10.
- R2: When stages 5 and 3 are both ALU-class, stage 3 is not an immediate form, the stage-5 destination equals source field C, and stage 4 does not also match, Y equals the stage-5 result and ySel is 2'b10.
- R3: When stages 4 and 3 are both ALU-class and the stage-4 destination equals source field B, X equals the stage-4 result and xSel is 2'b01.
- R4: When stages 4 and 3 are both ALU-class, stage 3 is not an immediate form, and the stage-4 destination equals source field C, Y equals the stage-4 result and ySel is 2'b01.
- R5: A producer stage whose ALU-class flag is low never supplies either operand, whatever its destination field holds.
- R6: When the stage-3 ALU-class flag is low, no forwarding happens: xSel and ySel are 2'b00 and X and Y equal the register-file values.
- R7: When stages 4 and 5 both match the same source field, the stage-4 result is chosen (code 2'b01).
- R8: When stage 3 is an immediate form, Y equals the immediate input and ySel is 2'b00. Forwarding of X is unchanged.
- R9: When no forwarding condition holds, X equals the field-B register value, Y equals the field-C register value, and both codes are 2'b00.
- R10: The select codes only take the values 2'b00 (register file or immediate), 2'b01 (stage 4) or 2'b10 (stage 5), never 2'b11. All outputs follow input changes within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s4Dest | input | 5 | Destination register field of the stage-4 instruction |
| s4IsAlu | input | 1 | Stage-4 instruction is ALU-class |
| s4Result | input | 32 | ALU result held in stage 4 |
| s5Dest | input | 5 | Destination register field of the stage-5 instruction |
| s5IsAlu | input | 1 | Stage-5 instruction is ALU-class |
| s5Result | input | 32 | ALU result held in stage 5 |
| s3SrcB | input | 5 | Source field feeding operand X |
| s3SrcC | input | 5 | Source field feeding operand Y |
| s3IsAlu | input | 1 | Stage-3 instruction is ALU-class |
| s3IsImm | input | 1 | Stage-3 instruction uses an immediate second operand |
| s3Imm | input | 32 | Immediate value of the stage-3 instruction |
| rfValB | input | 32 | Register-file read value for field B |
| rfValC | input | 32 | Register-file read value for field C |
| opX | output | 32 | Selected first operand |
| opY | output | 32 | Selected second operand |
| xSel | output | 2 | Path chosen for X |
| ySel | output | 2 | Path chosen for Y |

## Verification
Every result of this block is due in the same cycle as the stimulus that causes it, because there is no register between any input and any output. The bench applies each input pattern on the falling clock edge. It samples the four outputs 2 ns later, well before the next rising edge, so no check depends on a clock edge having passed. One directed test changes the stage-4 result and the immediate value in the middle of a cycle and checks that the operands track them before any edge arrives.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  parameter int REG_W    = 5;
  parameter int DATA_W   = 32;
  parameter int NUM_PROD = 2;   // producer stages: index 0 = stage 4, index 1 = stage 5

  // Path codes; the value of a producer code is its index plus one
  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_Z4 = 2'b01,
    SEL_Z5 = 2'b10
  } opSel_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    opSel_e xSel;
    opSel_e ySel;
    logic   yImm;
  } fwdStrobe_t;

endpackage

// File: rtl/fwd_match.sv
// Hazard comparator for one producer stage against the stage-3 consumer
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] prodDest,
  input  logic             prodAlu,
  input  logic             consAlu,
  input  logic             consImm,
  input  logic [REG_W-1:0] srcB,
  input  logic [REG_W-1:0] srcC,
  output logic             hitB,
  output logic             hitC
);

  logic bothAlu;

  always_comb begin
    bothAlu = prodAlu & consAlu;
    hitB    = bothAlu & (prodDest == srcB);
    hitC    = bothAlu & ~consImm & (prodDest == srcC);
  end

endmodule

// File: rtl/fwd_ctrl.sv
// Turns per-stage comparisons into prioritised select strobes
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_W    = fwd_pkg::REG_W,
  parameter int NUM_PROD = fwd_pkg::NUM_PROD
) (
  input  logic [NUM_PROD-1:0][REG_W-1:0] prodDest,
  input  logic [NUM_PROD-1:0]            prodAlu,
  input  logic                           consAlu,
  input  logic                           consImm,
  input  logic [REG_W-1:0]               srcB,
  input  logic [REG_W-1:0]               srcC,
  output fwdStrobe_t                     strobe
);

  logic [NUM_PROD-1:0] hitB;
  logic [NUM_PROD-1:0] hitC;

  for (genvar g = 0; g < NUM_PROD; g++) begin : g_cmp
    fwd_match #(.REG_W(REG_W)) u_match (
      .prodDest (prodDest[g]),
      .prodAlu  (prodAlu[g]),
      .consAlu  (consAlu),
      .consImm  (consImm),
      .srcB     (srcB),
      .srcC     (srcC),
      .hitB     (hitB[g]),
      .hitC     (hitC[g])
    );
  end

  // Walk from oldest to youngest so the youngest match overwrites
  always_comb begin
    strobe.xSel = SEL_RF;
    strobe.ySel = SEL_RF;
    strobe.yImm = consImm;
    for (int i = NUM_PROD - 1; i >= 0; i--) begin
      if (hitB[i]) strobe.xSel = opSel_e'(2'(i + 1));
      if (hitC[i]) strobe.ySel = opSel_e'(2'(i + 1));
    end
  end

endmodule

// File: rtl/fwd_datapath.sv
// Operand multiplexers steered by the control strobes
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = fwd_pkg::DATA_W
) (
  input  fwdStrobe_t        strobe,
  input  logic [DATA_W-1:0] z4,
  input  logic [DATA_W-1:0] z5,
  input  logic [DATA_W-1:0] rfB,
  input  logic [DATA_W-1:0] rfC,
  input  logic [DATA_W-1:0] immVal,
  output logic [DATA_W-1:0] opX,
  output logic [DATA_W-1:0] opY
);

  function automatic logic [DATA_W-1:0] pick(opSel_e sel,
                                             logic [DATA_W-1:0] base,
                                             logic [DATA_W-1:0] a4,
                                             logic [DATA_W-1:0] a5);
    case (sel)
      SEL_Z4:  return a4;
      SEL_Z5:  return a5;
      default: return base;
    endcase
  endfunction

  logic [DATA_W-1:0] yBase;

  always_comb begin
    yBase = strobe.yImm ? immVal : rfC;
    opX   = pick(strobe.xSel, rfB, z4, z5);
    opY   = pick(strobe.ySel, yBase, z4, z5);
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = fwd_pkg::REG_W,
  parameter int DATA_W = fwd_pkg::DATA_W
) (
  input  logic [REG_W-1:0]  s4Dest,
  input  logic              s4IsAlu,
  input  logic [DATA_W-1:0] s4Result,
  input  logic [REG_W-1:0]  s5Dest,
  input  logic              s5IsAlu,
  input  logic [DATA_W-1:0] s5Result,
  input  logic [REG_W-1:0]  s3SrcB,
  input  logic [REG_W-1:0]  s3SrcC,
  input  logic              s3IsAlu,
  input  logic              s3IsImm,
  input  logic [DATA_W-1:0] s3Imm,
  input  logic [DATA_W-1:0] rfValB,
  input  logic [DATA_W-1:0] rfValC,
  output logic [DATA_W-1:0] opX,
  output logic [DATA_W-1:0] opY,
  output logic [1:0]        xSel,
  output logic [1:0]        ySel
);

  localparam int NumProd = 2;

  fwdStrobe_t                   strobe;
  logic [NumProd-1:0][REG_W-1:0] prodDest;
  logic [NumProd-1:0]            prodAlu;

  assign prodDest = {s5Dest, s4Dest};
  assign prodAlu  = {s5IsAlu, s4IsAlu};

  fwd_ctrl #(.REG_W(REG_W), .NUM_PROD(NumProd)) u_ctrl (
    .prodDest (prodDest),
    .prodAlu  (prodAlu),
    .consAlu  (s3IsAlu),
    .consImm  (s3IsImm),
    .srcB     (s3SrcB),
    .srcC     (s3SrcC),
    .strobe   (strobe)
  );

  fwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe (strobe),
    .z4     (s4Result),
    .z5     (s5Result),
    .rfB    (rfValB),
    .rfC    (rfValC),
    .immVal (s3Imm),
    .opX    (opX),
    .opY    (opY)
  );

  assign xSel = strobe.xSel;
  assign ySel = strobe.ySel;

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  s4Dest,
  input logic              s4IsAlu,
  input logic [DATA_W-1:0] s4Result,
  input logic [REG_W-1:0]  s5Dest,
  input logic              s5IsAlu,
  input logic [DATA_W-1:0] s5Result,
  input logic [REG_W-1:0]  s3SrcB,
  input logic [REG_W-1:0]  s3SrcC,
  input logic              s3IsAlu,
  input logic              s3IsImm,
  input logic [DATA_W-1:0] s3Imm,
  input logic [DATA_W-1:0] rfValB,
  input logic [DATA_W-1:0] rfValC,
  input logic [DATA_W-1:0] opX,
  input logic [DATA_W-1:0] opY,
  input logic [1:0]        xSel,
  input logic [1:0]        ySel
);

  always_comb begin
    p_sel_legal_r10: assert (xSel != 2'b11 && ySel != 2'b11);
    if (xSel == 2'b01) p_x_z4_r3: assert (opX == s4Result);
    if (xSel == 2'b10) p_x_z5_r1: assert (opX == s5Result);
    if (xSel == 2'b00) p_x_rf_r9: assert (opX == rfValB);
    if (ySel == 2'b01) p_y_z4_r4: assert (opY == s4Result && !s3IsImm);
    if (ySel == 2'b10) p_y_z5_r2: assert (opY == s5Result && !s3IsImm);
    if (s3IsImm) p_y_imm_r8: assert (ySel == 2'b00 && opY == s3Imm);
    if (!s3IsAlu) p_no_cons_r6: assert (xSel == 2'b00 && ySel == 2'b00);
    if (!s4IsAlu) p_no_prod4_r5: assert (xSel != 2'b01 && ySel != 2'b01);
    if (!s5IsAlu) p_no_prod5_r5: assert (xSel != 2'b10 && ySel != 2'b10);
    if (s3IsAlu && s4IsAlu && s4Dest == s3SrcB) p_young_wins_r7: assert (xSel == 2'b01);
    if (s3IsAlu && s5IsAlu && s5Dest == s3SrcB && !(s4IsAlu && s4Dest == s3SrcB))
      p_x_old_r1: assert (xSel == 2'b10);
  end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .s4Dest(s4Dest), .s4IsAlu(s4IsAlu), .s4Result(s4Result),
  .s5Dest(s5Dest), .s5IsAlu(s5IsAlu), .s5Result(s5Result),
  .s3SrcB(s3SrcB), .s3SrcC(s3SrcC), .s3IsAlu(s3IsAlu), .s3IsImm(s3IsImm),
  .s3Imm(s3Imm), .rfValB(rfValB), .rfValC(rfValC),
  .opX(opX), .opY(opY), .xSel(xSel), .ySel(ySel)
);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  s4Dest, s5Dest, s3SrcB, s3SrcC;
  logic        s4IsAlu, s5IsAlu, s3IsAlu, s3IsImm;
  logic [31:0] s4Result, s5Result, s3Imm, rfValB, rfValC;
  logic [31:0] opX, opY;
  logic [1:0]  xSel, ySel;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fwd_unit u_dut (
    .s4Dest(s4Dest), .s4IsAlu(s4IsAlu), .s4Result(s4Result),
    .s5Dest(s5Dest), .s5IsAlu(s5IsAlu), .s5Result(s5Result),
    .s3SrcB(s3SrcB), .s3SrcC(s3SrcC), .s3IsAlu(s3IsAlu), .s3IsImm(s3IsImm),
    .s3Imm(s3Imm), .rfValB(rfValB), .rfValC(rfValC),
    .opX(opX), .opY(opY), .xSel(xSel), .ySel(ySel)
  );

  typedef struct packed {
    logic [4:0] d4; logic a4;
    logic [4:0] d5; logic a5;
    logic [4:0] b;  logic [4:0] c;
    logic a3; logic im;
    logic [1:0] ex; logic [1:0] ey;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  1'b1, 5'd7,  1'b1, 5'd3,  5'd9,  1'b1, 1'b0, 2'b01, 2'b00, 8'd3}, // R3
    '{5'd2,  1'b1, 5'd8,  1'b1, 5'd4,  5'd2,  1'b1, 1'b0, 2'b00, 2'b01, 8'd4}, // R4
    '{5'd1,  1'b1, 5'd6,  1'b1, 5'd6,  5'd11, 1'b1, 1'b0, 2'b10, 2'b00, 8'd1}, // R1
    '{5'd1,  1'b1, 5'd12, 1'b1, 5'd6,  5'd12, 1'b1, 1'b0, 2'b00, 2'b10, 8'd2}, // R2
    '{5'd5,  1'b1, 5'd5,  1'b1, 5'd5,  5'd5,  1'b1, 1'b0, 2'b01, 2'b01, 8'd7}, // R7
    '{5'd5,  1'b0, 5'd5,  1'b1, 5'd5,  5'd5,  1'b1, 1'b0, 2'b10, 2'b10, 8'd5}, // R5
    '{5'd5,  1'b0, 5'd5,  1'b0, 5'd5,  5'd5,  1'b1, 1'b0, 2'b00, 2'b00, 8'd5}, // R5
    '{5'd5,  1'b1, 5'd5,  1'b1, 5'd5,  5'd5,  1'b0, 1'b0, 2'b00, 2'b00, 8'd6}, // R6
    '{5'd9,  1'b1, 5'd9,  1'b1, 5'd9,  5'd9,  1'b1, 1'b1, 2'b01, 2'b00, 8'd8}, // R8
    '{5'd0,  1'b1, 5'd4,  1'b1, 5'd4,  5'd4,  1'b1, 1'b1, 2'b10, 2'b00, 8'd8}, // R8
    '{5'd1,  1'b1, 5'd2,  1'b1, 5'd3,  5'd4,  1'b1, 1'b0, 2'b00, 2'b00, 8'd9}, // R9
    '{5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  5'd0,  1'b1, 1'b0, 2'b01, 2'b01, 8'd7}, // R7
    '{5'd31, 1'b1, 5'd30, 1'b1, 5'd30, 5'd31, 1'b1, 1'b0, 2'b10, 2'b01, 8'd1}  // R1
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expData(logic [1:0] sel, logic [31:0] base);
    case (sel)
      2'b01:   return s4Result;
      2'b10:   return s5Result;
      default: return base;
    endcase
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    s4Dest = '0; s5Dest = '0; s3SrcB = '0; s3SrcC = '0;
    s4IsAlu = 1'b0; s5IsAlu = 1'b0; s3IsAlu = 1'b0; s3IsImm = 1'b0;
    s4Result = 32'h4444_0004; s5Result = 32'h5555_0005;
    s3Imm = 32'h1111_1111; rfValB = 32'hBBBB_000B; rfValC = 32'hCCCC_000C;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle state after reset: no ALU activity, register file paths (R6, R9)
    @(negedge clk); #2;
    chk("R6 idle xSel", {30'd0, xSel}, 32'd0);
    chk("R9 idle opX", opX, rfValB);
    chk("R9 idle opY", opY, rfValC);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      s4Dest = VECS[i].d4; s4IsAlu = VECS[i].a4;
      s5Dest = VECS[i].d5; s5IsAlu = VECS[i].a5;
      s3SrcB = VECS[i].b;  s3SrcC = VECS[i].c;
      s3IsAlu = VECS[i].a3; s3IsImm = VECS[i].im;
      #2;
      chk($sformatf("R%0d vec%0d xSel", VECS[i].req, i), {30'd0, xSel}, {30'd0, VECS[i].ex});
      chk($sformatf("R%0d vec%0d ySel", VECS[i].req, i), {30'd0, ySel}, {30'd0, VECS[i].ey});
      chk($sformatf("R%0d vec%0d opX", VECS[i].req, i), opX, expData(VECS[i].ex, rfValB));
      chk($sformatf("R%0d vec%0d opY", VECS[i].req, i), opY,
          expData(VECS[i].ey, VECS[i].im ? s3Imm : rfValC));
      chk("R10 no code 11", {31'd0, (xSel == 2'b11) || (ySel == 2'b11)}, 32'd0);
    end

    // R10: outputs follow inputs within the cycle, no edge in between
    @(negedge clk);
    s4Dest = 5'd3; s4IsAlu = 1'b1; s5Dest = 5'd7; s5IsAlu = 1'b1;
    s3SrcB = 5'd3; s3SrcC = 5'd20; s3IsAlu = 1'b1; s3IsImm = 1'b1;
    #1;
    chk("R10 X before change", opX, 32'h4444_0004);
    s4Result = 32'hDEAD_BEEF; s3Imm = 32'h0000_ABCD;
    #1;
    chk("R10 X tracks stage-4 result", opX, 32'hDEAD_BEEF);
    chk("R8 Y tracks immediate", opY, 32'h0000_ABCD);
    // R8: immediate form hides a stage-4 match on field C
    s3SrcC = 5'd3;
    #1;
    chk("R8 ySel with C match", {30'd0, ySel}, 32'd0);
    chk("R8 opY with C match", opY, 32'h0000_ABCD);
    // R2: leaving immediate form re-enables forwarding on Y, stage 5 only
    s3IsImm = 1'b0; s3SrcC = 5'd7;
    #1;
    chk("R2 ySel after imm off", {30'd0, ySel}, 32'd2);
    chk("R2 opY after imm off", opY, s5Result);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule